// File: doc/BRIEF.md
# Single-Wire Peripheral Bus Transaction Monitor with Service-Request Detection

This block listens to a single-wire, open-collector peripheral bus and never drives it. The line idles high. Every bit is a cell of about 100 µs: a low part followed by a high part. A host starts a transaction with a long low pulse, the attention signal. It then sends a command byte, most significant bit first, followed by a stop bit. A device may answer after a quiet high gap. The answer is a start bit, whole data bytes, and a closing stop bit.

A device that wants the host's attention stretches the low part of the command stop bit. The monitor does not treat this as an aborted transaction. It raises a service-request flag, restarts its gap timing at the end of the stretched low, and goes on to decode any reply.

Each finished transaction produces one report on a valid/ready output. The report holds the command fields, the service-request flag, the number of complete reply bytes, and the bytes themselves. The bus cannot be paused, so back-pressure cannot stall decoding:
- While a report waits for `rpt_ready`, it stays stable.
- A transaction that finishes during that wait is discarded.
- With `rpt_ready` held high, `rpt_valid` is a one-cycle frame-done strobe.

Pulse widths are measured in 1 µs ticks. The ticks are derived from the clock by the `TICK_DIV` parameter, after a two-flop synchronizer on the line.

Top module: `srq_bus_monitor`

## Requirements
- R1: After reset `rpt_valid` is 0, and no report appears while the line stays high.
- R2: A low pulse of at least `ATTN_US` (800) µs starts a new transaction and abandons any transaction in progress without a report.
- R3: A bit whose low part is shorter than its following high part is 1; otherwise it is 0. The command byte is sent most significant bit first. It is reported as:
  - `rpt_addr` = bits 7:4
  - `rpt_code` = bits 3:2 (11 Talk, 10 Listen)
  - `rpt_reg` = bits 1:0
- R4: A command stop bit whose low part is shorter than `STOP_MAX_US` (100) µs is a plain stop, and the report has `rpt_srq` = 0.
- R5: A command stop low of `SRQ_MIN_US` (140) to `SRQ_MAX_US` (500) µs inclusive is a service request. The report has `rpt_srq` = 1. Gap timing and reply decoding start from the end of that low, so a full reply is still captured.
- R6: A command stop low of 100–139 µs, or of 501–799 µs, is malformed. The transaction is dropped with no report.
- R7: If no falling edge follows within `GAP_US` (260) µs of the end of the command stop low, the report is issued with `rpt_count` = 0 and all data zero.
- R8: Reply decoding:
  - The first reply bit is a start bit and is discarded.
  - The following bits fill bytes, most significant bit first. Byte k is placed at `rpt_data[8k+7:8k]`.
  - The frame ends once the line has been high for `END_US` (200) µs.
  - `rpt_count` is the number of complete bytes, and trailing partial bits are dropped.
  - Bytes beyond `MAX_BYTES` are not stored, and the count stops at `MAX_BYTES`.
- R9: The service-request flag and the byte count are held in separate state. A service request leaves the count of a full reply intact, and reply bytes never change the flag.
- R10: While `rpt_valid` is high and `rpt_ready` is low, every report field holds. A transaction finishing during that wait is discarded. `rpt_valid` falls on the edge after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, `TICK_DIV` cycles per µs tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 1 | Sampled bus line (idle high) |
| rpt_valid | output | 1 | Report available |
| rpt_ready | input | 1 | Report accepted when high with `rpt_valid` |
| rpt_addr | output | 4 | Device address from the command byte |
| rpt_code | output | 2 | Command code (11 Talk, 10 Listen) |
| rpt_reg | output | 2 | Register number |
| rpt_srq | output | 1 | Service request seen on the command stop bit |
| rpt_count | output | $clog2(MAX_BYTES+1) | Complete reply bytes captured |
| rpt_data | output | 8*MAX_BYTES | Reply bytes, byte 0 in bits 7:0 |

## Verification
A report is due a fixed quiet time after the line's final rise, plus a few clock cycles for the synchronizer, the edge detector and the output register:
- `END_US` µs after the closing stop bit when a reply was seen.
- `GAP_US` µs after the command stop bit when no reply was seen.

For each transaction the bench first confirms that `rpt_valid` is still low 50–60 µs before that point. It then polls in a window of a few tens of µs around the due time and compares the fields on the cycle the strobe appears. In the back-pressure test, the state change is checked on the clock edge right after `rpt_ready` rises.

// File: rtl/bmon_pkg.sv
package bmon_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ATTN,
    ST_CMD,
    ST_STOP,
    ST_GAP,
    ST_DATA
  } mon_state_t;

  localparam logic [1:0] CODE_TALK   = 2'b11;
  localparam logic [1:0] CODE_LISTEN = 2'b10;

endpackage

// File: rtl/bmon_sync.sv
module bmon_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RESET_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/bmon_pulse_timer.sv
module bmon_pulse_timer #(
  parameter int unsigned TICK_DIV = 8,
  parameter int unsigned LEN_W    = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line,
  output logic             level,
  output logic             rose,
  output logic             fell,
  output logic [LEN_W-1:0] width
);

  logic             line_d;
  logic             tick;
  logic [LEN_W-1:0] cnt;
  logic             edge_seen;

  // microsecond tick: direct when the clock already runs at the tick rate
  generate
    if (TICK_DIV <= 1) begin : g_direct
      assign tick = 1'b1;
    end else begin : g_div
      localparam int unsigned DW = $clog2(TICK_DIV);
      localparam logic [DW-1:0] DIV_LAST = DW'(TICK_DIV - 1);
      logic [DW-1:0] div;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               div <= '0;
        else if (div == DIV_LAST) div <= '0;
        else                      div <= div + 1'b1;
      end
      assign tick = (div == DIV_LAST);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_d <= 1'b1;
    else        line_d <= line;
  end

  assign edge_seen = line ^ line_d;

  // width of the level in progress, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (edge_seen)          cnt <= tick ? LEN_W'(1) : '0;
    else if (tick && cnt != '1)  cnt <= cnt + 1'b1;
  end

  assign level = line;
  assign rose  = line & ~line_d;
  assign fell  = ~line & line_d;
  assign width = cnt;

  AST_EDGE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (rose || fell) |=> (width <= LEN_W'(1))); // R3

endmodule

// File: rtl/bmon_frame_fsm.sv
module bmon_frame_fsm
  import bmon_pkg::*;
#(
  parameter int unsigned LEN_W      = 11,
  parameter int unsigned MAX_BYTES  = 8,
  parameter int unsigned CNT_W      = 4,
  parameter int unsigned ATTN_US    = 800,
  parameter int unsigned STOP_MAX_US = 100,
  parameter int unsigned SRQ_MIN_US = 140,
  parameter int unsigned SRQ_MAX_US = 500,
  parameter int unsigned GAP_US     = 260,
  parameter int unsigned END_US     = 200
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   level,
  input  logic                   rose,
  input  logic                   fell,
  input  logic [LEN_W-1:0]       width,
  output logic                   done,
  output logic [7:0]             cmd_byte,
  output logic                   srq,
  output logic [CNT_W-1:0]       byte_cnt,
  output logic [MAX_BYTES*8-1:0] data
);

  localparam logic [LEN_W-1:0] ATTN_L    = LEN_W'(ATTN_US);
  localparam logic [LEN_W-1:0] STOPMAX_L = LEN_W'(STOP_MAX_US);
  localparam logic [LEN_W-1:0] SRQMIN_L  = LEN_W'(SRQ_MIN_US);
  localparam logic [LEN_W-1:0] SRQMAX_L  = LEN_W'(SRQ_MAX_US);
  localparam logic [LEN_W-1:0] GAP_L     = LEN_W'(GAP_US);
  localparam logic [LEN_W-1:0] END_L     = LEN_W'(END_US);
  localparam logic [CNT_W-1:0] MAX_C     = CNT_W'(MAX_BYTES);

  mon_state_t               state;
  logic [7:0]               cmd_sh;
  logic [2:0]               cmd_n;
  logic [LEN_W-1:0]         low_q;
  logic                     have_low;
  logic                     start_pend;
  logic [7:0]               byte_sh;
  logic [2:0]               sub_n;
  logic                     srq_q;
  logic [CNT_W-1:0]         cnt_q;
  logic [MAX_BYTES*8-1:0]   data_q;

  logic                     cell_bit;
  logic [7:0]               new_byte;
  logic                     attention;

  // a cell is a one when its low part is shorter than its high part
  assign cell_bit  = (low_q < width);
  assign new_byte  = {byte_sh[6:0], cell_bit};
  assign attention = !level && (width >= ATTN_L) && (state != ST_ATTN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cmd_sh     <= '0;
      cmd_n      <= '0;
      low_q      <= '0;
      have_low   <= 1'b0;
      start_pend <= 1'b0;
      byte_sh    <= '0;
      sub_n      <= '0;
      srq_q      <= 1'b0;
      cnt_q      <= '0;
      data_q     <= '0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (attention) begin
        state      <= ST_ATTN;
        cmd_sh     <= '0;
        cmd_n      <= '0;
        have_low   <= 1'b0;
        start_pend <= 1'b0;
        byte_sh    <= '0;
        sub_n      <= '0;
        srq_q      <= 1'b0;
        cnt_q      <= '0;
        data_q     <= '0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ATTN: begin
            if (rose) begin
              state    <= ST_CMD;
              have_low <= 1'b0;
              cmd_n    <= '0;
            end
          end
          ST_CMD: begin
            if (rose) begin
              low_q    <= width;
              have_low <= 1'b1;
            end else if (fell && have_low) begin
              cmd_sh   <= {cmd_sh[6:0], cell_bit};
              have_low <= 1'b0;
              if (cmd_n == 3'd7) state <= ST_STOP;
              else               cmd_n <= cmd_n + 1'b1;
            end else if (level && width >= END_L) begin
              state <= ST_IDLE;
            end
          end
          ST_STOP: begin
            if (rose) begin
              if (width < STOPMAX_L) begin
                srq_q <= 1'b0;
                state <= ST_GAP;
              end else if (width >= SRQMIN_L && width <= SRQMAX_L) begin
                srq_q <= 1'b1;
                state <= ST_GAP;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_GAP: begin
            if (fell) begin
              state      <= ST_DATA;
              have_low   <= 1'b0;
              start_pend <= 1'b1;
              sub_n      <= '0;
            end else if (level && width >= GAP_L) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end
          end
          ST_DATA: begin
            if (rose) begin
              low_q    <= width;
              have_low <= 1'b1;
            end else if (fell && have_low) begin
              have_low <= 1'b0;
              if (start_pend) begin
                start_pend <= 1'b0;
              end else begin
                byte_sh <= new_byte;
                if (sub_n == 3'd7) begin
                  sub_n <= '0;
                  if (cnt_q < MAX_C) begin
                    for (int k = 0; k < int'(MAX_BYTES); k++) begin
                      if (cnt_q == CNT_W'(k)) data_q[k*8 +: 8] <= new_byte;
                    end
                    cnt_q <= cnt_q + 1'b1;
                  end
                end else begin
                  sub_n <= sub_n + 1'b1;
                end
              end
            end else if (level && width >= END_L) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign cmd_byte = cmd_sh;
  assign srq      = srq_q;
  assign byte_cnt = cnt_q;
  assign data     = data_q;

  AST_ATTN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ATTN) |-> (srq_q == 1'b0 && cnt_q == '0)); // R2
  AST_GAP_NO_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GAP) |-> (cnt_q == '0)); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= MAX_C); // R8
  AST_DONE_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(level)); // R8
  AST_SRQ_ONLY_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(srq_q) |-> ($past(state) == ST_STOP || state == ST_ATTN)); // R9
  AST_CNT_ONLY_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_q) |-> ($past(state) == ST_DATA || state == ST_ATTN)); // R9

endmodule

// File: rtl/srq_bus_monitor.sv
module srq_bus_monitor #(
  parameter int unsigned TICK_DIV    = 8,
  parameter int unsigned MAX_BYTES   = 8,
  parameter int unsigned ATTN_US     = 800,
  parameter int unsigned STOP_MAX_US = 100,
  parameter int unsigned SRQ_MIN_US  = 140,
  parameter int unsigned SRQ_MAX_US  = 500,
  parameter int unsigned GAP_US      = 260,
  parameter int unsigned END_US      = 200,
  localparam int unsigned CNT_W      = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_in,
  output logic                   rpt_valid,
  input  logic                   rpt_ready,
  output logic [3:0]             rpt_addr,
  output logic [1:0]             rpt_code,
  output logic [1:0]             rpt_reg,
  output logic                   rpt_srq,
  output logic [CNT_W-1:0]       rpt_count,
  output logic [MAX_BYTES*8-1:0] rpt_data
);

  localparam int unsigned LEN_W = $clog2(ATTN_US + 1) + 1;

  logic                   line_s;
  logic                   level;
  logic                   rose;
  logic                   fell;
  logic [LEN_W-1:0]       width;
  logic                   f_done;
  logic [7:0]             f_cmd;
  logic                   f_srq;
  logic [CNT_W-1:0]       f_cnt;
  logic [MAX_BYTES*8-1:0] f_data;
  logic                   load;

  bmon_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (bus_in),
    .q     (line_s)
  );

  bmon_pulse_timer #(.TICK_DIV(TICK_DIV), .LEN_W(LEN_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .line  (line_s),
    .level (level),
    .rose  (rose),
    .fell  (fell),
    .width (width)
  );

  bmon_frame_fsm #(
    .LEN_W       (LEN_W),
    .MAX_BYTES   (MAX_BYTES),
    .CNT_W       (CNT_W),
    .ATTN_US     (ATTN_US),
    .STOP_MAX_US (STOP_MAX_US),
    .SRQ_MIN_US  (SRQ_MIN_US),
    .SRQ_MAX_US  (SRQ_MAX_US),
    .GAP_US      (GAP_US),
    .END_US      (END_US)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (level),
    .rose     (rose),
    .fell     (fell),
    .width    (width),
    .done     (f_done),
    .cmd_byte (f_cmd),
    .srq      (f_srq),
    .byte_cnt (f_cnt),
    .data     (f_data)
  );

  // a finished frame is taken only when the slot is free or being emptied
  assign load = f_done && (!rpt_valid || rpt_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpt_valid <= 1'b0;
      rpt_addr  <= '0;
      rpt_code  <= '0;
      rpt_reg   <= '0;
      rpt_srq   <= 1'b0;
      rpt_count <= '0;
      rpt_data  <= '0;
    end else if (load) begin
      rpt_valid <= 1'b1;
      rpt_addr  <= f_cmd[7:4];
      rpt_code  <= f_cmd[3:2];
      rpt_reg   <= f_cmd[1:0];
      rpt_srq   <= f_srq;
      rpt_count <= f_cnt;
      rpt_data  <= f_data;
    end else if (rpt_ready) begin
      rpt_valid <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && !rpt_ready) |=> (rpt_valid && $stable(rpt_addr) && $stable(rpt_code) && $stable(rpt_reg) && $stable(rpt_srq) && $stable(rpt_count) && $stable(rpt_data))); // R10
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && rpt_ready && !f_done) |=> !rpt_valid); // R10

endmodule

// File: tb/test_srq_bus_monitor.sv
module test_srq_bus_monitor;

  localparam int TD   = 1;
  localparam int MAXB = 2;
  localparam int CW   = $clog2(MAXB + 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic              bus;
  logic              rdy;
  logic              rpt_valid;
  logic [3:0]        rpt_addr;
  logic [1:0]        rpt_code;
  logic [1:0]        rpt_reg;
  logic              rpt_srq;
  logic [CW-1:0]     rpt_count;
  logic [MAXB*8-1:0] rpt_data;

  srq_bus_monitor #(.TICK_DIV(TD), .MAX_BYTES(MAXB)) i_srq_bus_monitor (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_in    (bus),
    .rpt_valid (rpt_valid),
    .rpt_ready (rdy),
    .rpt_addr  (rpt_addr),
    .rpt_code  (rpt_code),
    .rpt_reg   (rpt_reg),
    .rpt_srq   (rpt_srq),
    .rpt_count (rpt_count),
    .rpt_data  (rpt_data)
  );

  typedef struct packed {
    logic [7:0]  cmd;
    logic [9:0]  stop_us;
    logic [4:0]  nbits;
    logic [23:0] rdata;
    logic        exp_rpt;
    logic        exp_srq;
    logic [1:0]  exp_cnt;
    logic [15:0] exp_data;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'h2F, 10'd65,  5'd16, 24'h006202, 1'b1, 1'b0, 2'd2, 16'h0262}, // R3 R4 R8
    '{8'h3F, 10'd300, 5'd16, 24'h006901, 1'b1, 1'b1, 2'd2, 16'h0169}, // R5 R9
    '{8'h5F, 10'd300, 5'd0,  24'h000000, 1'b1, 1'b1, 2'd0, 16'h0000}, // R7 R9
    '{8'hFF, 10'd65,  5'd0,  24'h000000, 1'b1, 1'b0, 2'd0, 16'h0000}, // R7
    '{8'h2B, 10'd65,  5'd16, 24'h000FFE, 1'b1, 1'b0, 2'd2, 16'hFE0F}, // R3 listen
    '{8'h3B, 10'd145, 5'd16, 24'h000FFE, 1'b1, 1'b1, 2'd2, 16'hFE0F}, // R5 low edge
    '{8'h0C, 10'd490, 5'd0,  24'h000000, 1'b1, 1'b1, 2'd0, 16'h0000}, // R5 high edge
    '{8'h2F, 10'd120, 5'd0,  24'h000000, 1'b0, 1'b0, 2'd0, 16'h0000}, // R6
    '{8'h2F, 10'd600, 5'd0,  24'h000000, 1'b0, 1'b0, 2'd0, 16'h0000}, // R6
    '{8'h1D, 10'd65,  5'd24, 24'hA55A3C, 1'b1, 1'b0, 2'd2, 16'h5AA5}, // R8 saturate
    '{8'h1D, 10'd65,  5'd12, 24'h000C3F, 1'b1, 1'b0, 2'd1, 16'h00C3}, // R8 partial
    '{8'h7D, 10'd65,  5'd8,  24'h000081, 1'b1, 1'b0, 2'd1, 16'h0081}  // R3 R8
  };

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int us);
    bus = v;
    repeat (us * TD) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    if (b) begin drive(1'b0, 35); drive(1'b1, 65); end
    else   begin drive(1'b0, 65); drive(1'b1, 35); end
  endtask

  task automatic send_attn();
    drive(1'b0, 850);
    drive(1'b1, 65);
  endtask

  task automatic send_frame(input logic [7:0] cmd, input int stop_us,
                            input int nbits, input logic [23:0] rdata);
    send_attn();
    for (int i = 7; i >= 0; i--) send_bit(cmd[i]);
    drive(1'b0, stop_us);
    bus = 1'b1;
    if (nbits > 0) begin
      drive(1'b1, 200);
      send_bit(1'b1);
      for (int i = nbits - 1; i >= 0; i--) send_bit(rdata[i]);
      drive(1'b0, 65);
      bus = 1'b1;
    end
  endtask

  // waits for a report from the line's final rise; checks it is not early
  task automatic wait_report(input int early_us, input int due_us, input string req, output bit got);
    got = 1'b0;
    repeat (early_us * TD) @(negedge clk);
    chk(rpt_valid == 1'b0, req, "report before quiet time", {31'd0, rpt_valid}, 32'd0);
    for (int c = 0; c < (due_us - early_us + 20) * TD; c++) begin
      @(negedge clk);
      if (rpt_valid) begin got = 1'b1; break; end
    end
  endtask

  initial begin
    bit got;
    bus   = 1'b1;
    rdy   = 1'b1;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state and idle line
    chk(rpt_valid == 1'b0, "R1", "valid after reset", {31'd0, rpt_valid}, 32'd0);
    got = 1'b0;
    for (int c = 0; c < 1000 * TD; c++) begin
      @(negedge clk);
      if (rpt_valid) got = 1'b1;
    end
    chk(!got, "R1", "report on idle line", {31'd0, got}, 32'd0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      int early;
      int due;
      t = VECS[v];
      send_frame(t.cmd, int'(t.stop_us), int'(t.nbits), t.rdata);
      early = (t.nbits != 0) ? 150 : 200;
      due   = (t.nbits != 0) ? 200 : 260;
      wait_report(early, due, (t.nbits != 0) ? "R8" : "R7", got);
      if (t.exp_rpt) begin
        chk(got, "R8", $sformatf("vec %0d report seen", v), {31'd0, got}, 32'd1);
        chk(rpt_addr == t.cmd[7:4], "R3", $sformatf("vec %0d addr", v), 32'(rpt_addr), 32'(t.cmd[7:4]));
        chk(rpt_code == t.cmd[3:2] && rpt_reg == t.cmd[1:0], "R3",
            $sformatf("vec %0d code/reg", v), {28'd0, rpt_code, rpt_reg}, {28'd0, t.cmd[3:0]});
        chk(rpt_srq == t.exp_srq, t.exp_srq ? "R5" : "R4", $sformatf("vec %0d srq", v),
            {31'd0, rpt_srq}, {31'd0, t.exp_srq});
        chk(rpt_count == t.exp_cnt && rpt_srq == t.exp_srq, "R9", $sformatf("vec %0d count+srq", v),
            {29'd0, rpt_srq, rpt_count}, {29'd0, t.exp_srq, t.exp_cnt});
        chk(rpt_data == t.exp_data, "R8", $sformatf("vec %0d data", v), 32'(rpt_data), 32'(t.exp_data));
      end else begin
        chk(!got, "R6", $sformatf("vec %0d malformed stop reported", v), {31'd0, got}, 32'd0);
      end
      drive(1'b1, 100);
    end

    // R2: attention in the middle of a command restarts decoding
    send_attn();
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    send_frame(8'h3F, 65, 16, 24'h006901);
    wait_report(150, 200, "R2", got);
    chk(got && rpt_addr == 4'h3 && rpt_count == CW'(2) && rpt_data == 16'h0169, "R2",
        "restart after attention", {16'd0, rpt_addr, 2'd0, rpt_count, 8'd0}, {16'd0, 4'h3, 2'd0, CW'(2), 8'd0});
    drive(1'b1, 100);

    // R10: back-pressure holds the report and drops a later frame
    rdy = 1'b0;
    send_frame(8'h2F, 65, 16, 24'h006202);
    wait_report(150, 200, "R10", got);
    repeat (50) @(negedge clk);
    chk(rpt_valid && rpt_addr == 4'h2 && rpt_data == 16'h0262, "R10", "held report",
        {15'd0, rpt_valid, rpt_addr, rpt_data[11:0]}, {15'd0, 1'b1, 4'h2, 12'h262});
    send_frame(8'h5C, 300, 0, 24'h0);
    repeat (320 * TD) @(negedge clk);
    chk(rpt_valid && rpt_addr == 4'h2 && rpt_srq == 1'b0, "R10", "pending report kept",
        {27'd0, rpt_valid, rpt_addr}, {27'd0, 1'b1, 4'h2});
    rdy = 1'b1;
    @(negedge clk);
    chk(rpt_valid == 1'b0, "R10", "valid after accept", {31'd0, rpt_valid}, 32'd0);
    got = 1'b0;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (rpt_valid) got = 1'b1;
    end
    chk(!got, "R10", "dropped frame surfaced", {31'd0, got}, 32'd0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule